// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits behind the bit-recovery stage of one ARINC 429 receive channel. For every 32-bit word presented with a valid strobe, it decides in that same cycle whether to keep or discard the word. Two checks make the decision, and each can be switched on or off on its own. The first looks the label up in a loadable table of sixteen labels. The second compares the two source/destination bits with a programmed pair. A word that passes every enabled check is pushed into a 32-word receive FIFO.

A host loads the label table through a small port while a table-mode input is held high. Writes fill the entries in sequence, and reads return them in the same sequence. Each time the mode input rises, both sequences start again at entry 0.

The FIFO side has a registered read port and three registered flags: data ready, half full and full. Each flag also has an active-low copy. Bit numbering follows the line convention: line bit n is `word_data[n-1]`.

Top module: `a429_rx_filter`

## Requirements
- R1: During and after synchronous reset, `data_ready`, `half_full` and `full` are 0 and their active-low copies are 1. `fifo_rdata` and `host_rdata` are 0, and every label table entry holds 8'h00.
- R2: The label is `word_data[7:0]`. With `lbl_chk_en`=0 every label is accepted. With `lbl_chk_en`=1 a word is kept only if its label equals one of the 16 table entries.
- R3: With `sdi_chk_en`=1 a word is kept only if `word_data[8]` equals `sdi_match[0]` and `word_data[9]` equals `sdi_match[1]`. With `sdi_chk_en`=0 those bits are not examined.
- R4: A word is stored only when every enabled check passes. The checks use the word and the configuration of the strobe cycle, and the stored word and the updated flags appear after that same clock edge.
- R5: While `lbl_mode`=1, each `host_wr` writes `host_wdata` to the next table entry, in order 0 to 15, wrapping after 15. The cycle in which `lbl_mode` rises addresses entry 0.
- R6: While `lbl_mode`=1, each `host_rd` places the next table entry on `host_rdata` after the clock edge. Reads use the same order, the same wrap and the same restart on a rise of `lbl_mode`.
- R7: While `lbl_mode`=0, `host_wr` and `host_rd` have no effect: the table and `host_rdata` are unchanged.
- R8: `fifo_rd` removes the oldest stored word and shows it on `fifo_rdata` after the clock edge. A read of an empty FIFO leaves `fifo_rdata` unchanged.
- R9: `data_ready` is 1 while the FIFO holds at least one word and returns to 0 when the last word is read.
- R10: `half_full` is 1 exactly while the FIFO holds 16 or more words.
- R11: `full` is 1 while the FIFO holds 32 words. A word offered while `full` is 1 is dropped, even if a read happens in the same cycle, and the stored words are not changed.
- R12: `data_ready_n`, `half_full_n` and `full_n` are always the inverse of `data_ready`, `half_full` and `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Received word strobe, one cycle per word |
| word_data | input | 32 | Received word, line bit n on index n-1 |
| lbl_chk_en | input | 1 | Enable label table check |
| sdi_chk_en | input | 1 | Enable SDI bit check |
| sdi_match | input | 2 | Required values of line bits 10 and 9 |
| lbl_mode | input | 1 | Label table load/readback mode |
| host_wr | input | 1 | Write next table entry |
| host_wdata | input | 8 | Label to write |
| host_rd | input | 1 | Read next table entry |
| host_rdata | output | 8 | Label read back |
| fifo_rd | input | 1 | Pop oldest stored word |
| fifo_rdata | output | 32 | Popped word |
| data_ready | output | 1 | FIFO not empty |
| half_full | output | 1 | FIFO holds 16 or more words |
| full | output | 1 | FIFO holds 32 words |
| data_ready_n | output | 1 | Inverse of data_ready |
| half_full_n | output | 1 | Inverse of half_full |
| full_n | output | 1 | Inverse of full |

## Verification
The properties assume that the configuration inputs (`lbl_chk_en`, `sdi_chk_en`, `sdi_match`) are steady for a whole strobe cycle. They also assume that `lbl_mode` changes only between host accesses, so each rise of the mode is seen as one edge. The stimulus changes every input on the falling clock edge. It holds the configuration constant across each group of words and toggles `lbl_mode` with at least one idle cycle on either side. No property depends on when `word_valid` or `fifo_rd` are asserted, so the bench pairs a push with a read only where the full-FIFO drop rule is under test.

// File: rtl/a429_filt_pkg.sv
`timescale 1ns/1ps
package a429_filt_pkg;
  localparam int WORD_W  = 32;
  localparam int LABEL_W = 8;
  localparam int SDI_LSB = 8;   // line bits 9 and 10

  typedef struct packed {
    logic       lbl_chk_en;
    logic       sdi_chk_en;
    logic [1:0] sdi_match;
  } filt_cfg_t;
endpackage

// File: rtl/a429_label_table.sv
`timescale 1ns/1ps
module a429_label_table #(
  parameter int NUM = 16,
  parameter int LW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  logic          wr,
  input  logic [LW-1:0] wdata,
  input  logic          rd,
  output logic [LW-1:0] rdata,
  input  logic [LW-1:0] probe,
  output logic          hit
);
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1;
  localparam logic [IW-1:0] LAST = IW'(NUM - 1);

  logic [LW-1:0] tbl [NUM];
  logic          mode_q;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [IW-1:0] wr_sel, rd_sel;
  logic          start;
  logic [NUM-1:0] hit_vec;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == LAST) ? '0 : i + IW'(1);
  endfunction

  assign start  = mode & ~mode_q;
  assign wr_sel = start ? '0 : wr_idx;
  assign rd_sel = start ? '0 : rd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      wr_idx <= '0;
      rd_idx <= '0;
      rdata  <= '0;
      for (int i = 0; i < NUM; i++) tbl[i] <= '0;
    end else begin
      mode_q <= mode;
      if (start) begin
        wr_idx <= '0;
        rd_idx <= '0;
      end
      if (mode && wr) begin
        tbl[wr_sel] <= wdata;
        wr_idx      <= step(wr_sel);
      end
      if (mode && rd) begin
        rdata  <= tbl[rd_sel];
        rd_idx <= step(rd_sel);
      end
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign hit_vec[g] = (tbl[g] == probe);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/a429_word_accept.sv
`timescale 1ns/1ps
module a429_word_accept
  import a429_filt_pkg::*;
(
  input  logic               valid,
  input  logic [WORD_W-1:0]  word,
  input  filt_cfg_t          cfg,
  input  logic               lbl_hit,
  output logic [LABEL_W-1:0] label,
  output logic               accept
);
  logic lbl_ok, sdi_ok;

  always_comb begin
    label  = word[LABEL_W-1:0];
    lbl_ok = ~cfg.lbl_chk_en | lbl_hit;
    sdi_ok = ~cfg.sdi_chk_en | (word[SDI_LSB +: 2] == cfg.sdi_match);
    accept = valid & lbl_ok & sdi_ok;
  end
endmodule

// File: rtl/a429_rx_fifo.sv
`timescale 1ns/1ps
module a429_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         ready,
  output logic         half,
  output logic         full,
  output logic         ready_n,
  output logic         half_n,
  output logic         full_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign do_push = push & (cnt != FULL_CNT);
  assign do_pop  = pop & (cnt != '0);

  always_comb begin
    case ({do_push, do_pop})
      2'b10:   cnt_nxt = cnt + CW'(1);
      2'b01:   cnt_nxt = cnt - CW'(1);
      default: cnt_nxt = cnt;
    endcase
  end

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      dout    <= '0;
      ready   <= 1'b0;
      half    <= 1'b0;
      full    <= 1'b0;
      ready_n <= 1'b1;
      half_n  <= 1'b1;
      full_n  <= 1'b1;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop) begin
        dout   <= mem[rd_ptr];
        rd_ptr <= bump(rd_ptr);
      end
      cnt     <= cnt_nxt;
      ready   <= (cnt_nxt != '0);
      half    <= (cnt_nxt >= HALF_CNT);
      full    <= (cnt_nxt == FULL_CNT);
      ready_n <= (cnt_nxt == '0);
      half_n  <= (cnt_nxt < HALF_CNT);
      full_n  <= (cnt_nxt != FULL_CNT);
    end
  end
endmodule

// File: rtl/a429_rx_filter.sv
`timescale 1ns/1ps
module a429_rx_filter
  import a429_filt_pkg::*;
#(
  parameter int NUM_LABELS = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [WORD_W-1:0]  word_data,
  input  logic               lbl_chk_en,
  input  logic               sdi_chk_en,
  input  logic [1:0]         sdi_match,
  input  logic               lbl_mode,
  input  logic               host_wr,
  input  logic [LABEL_W-1:0] host_wdata,
  input  logic               host_rd,
  output logic [LABEL_W-1:0] host_rdata,
  input  logic               fifo_rd,
  output logic [WORD_W-1:0]  fifo_rdata,
  output logic               data_ready,
  output logic               half_full,
  output logic               full,
  output logic               data_ready_n,
  output logic               half_full_n,
  output logic               full_n
);
  filt_cfg_t          cfg;
  logic [LABEL_W-1:0] probe;
  logic               lbl_hit;
  logic               accept;

  assign cfg = '{lbl_chk_en: lbl_chk_en, sdi_chk_en: sdi_chk_en, sdi_match: sdi_match};

  a429_label_table #(.NUM(NUM_LABELS), .LW(LABEL_W)) u_tbl (
    .clk   (clk),
    .rst   (rst),
    .mode  (lbl_mode),
    .wr    (host_wr),
    .wdata (host_wdata),
    .rd    (host_rd),
    .rdata (host_rdata),
    .probe (probe),
    .hit   (lbl_hit)
  );

  a429_word_accept u_acc (
    .valid   (word_valid),
    .word    (word_data),
    .cfg     (cfg),
    .lbl_hit (lbl_hit),
    .label   (probe),
    .accept  (accept)
  );

  a429_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push    (accept),
    .din     (word_data),
    .pop     (fifo_rd),
    .dout    (fifo_rdata),
    .ready   (data_ready),
    .half    (half_full),
    .full    (full),
    .ready_n (data_ready_n),
    .half_n  (half_full_n),
    .full_n  (full_n)
  );
endmodule

// File: rtl/a429_rx_filter_chk.sv
`timescale 1ns/1ps
module a429_rx_filter_chk (
  input logic        clk,
  input logic        rst,
  input logic        word_valid,
  input logic [31:0] word_data,
  input logic        lbl_chk_en,
  input logic        sdi_chk_en,
  input logic [1:0]  sdi_match,
  input logic        lbl_mode,
  input logic        host_rd,
  input logic [7:0]  host_rdata,
  input logic        fifo_rd,
  input logic [31:0] fifo_rdata,
  input logic        data_ready,
  input logic        half_full,
  input logic        full,
  input logic        data_ready_n,
  input logic        half_full_n,
  input logic        full_n
);
  // R12
  pins_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    (data_ready_n == !data_ready) && (half_full_n == !half_full) && (full_n == !full));

  // R10
  half_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    half_full |-> data_ready);

  // R11
  full_needs_half_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> half_full);

  // R11
  full_holds_chk: assert property (@(posedge clk) disable iff (rst)
    full && !fifo_rd |=> full);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    !data_ready && fifo_rd |=> $stable(fifo_rdata));

  // R7
  host_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(lbl_mode && host_rd) |=> $stable(host_rdata));

  // R9
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(word_valid));

  // R3
  sdi_reject_chk: assert property (@(posedge clk) disable iff (rst)
    sdi_chk_en && word_valid && (word_data[9:8] != sdi_match) && !data_ready |=> !data_ready);

  // R2
  open_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !lbl_chk_en && !sdi_chk_en && word_valid && !full |=> data_ready);
endmodule

bind a429_rx_filter a429_rx_filter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .word_valid   (word_valid),
  .word_data    (word_data),
  .lbl_chk_en   (lbl_chk_en),
  .sdi_chk_en   (sdi_chk_en),
  .sdi_match    (sdi_match),
  .lbl_mode     (lbl_mode),
  .host_rd      (host_rd),
  .host_rdata   (host_rdata),
  .fifo_rd      (fifo_rd),
  .fifo_rdata   (fifo_rdata),
  .data_ready   (data_ready),
  .half_full    (half_full),
  .full         (full),
  .data_ready_n (data_ready_n),
  .half_full_n  (half_full_n),
  .full_n       (full_n)
);

// File: tb/sim_a429_rx_filter.sv
`timescale 1ns/1ps
module sim_a429_rx_filter;
  logic        clk = 1'b0;
  logic        rst;
  logic        word_valid;
  logic [31:0] word_data;
  logic        lbl_chk_en, sdi_chk_en;
  logic [1:0]  sdi_match;
  logic        lbl_mode, host_wr, host_rd, fifo_rd;
  logic [7:0]  host_wdata, host_rdata;
  logic [31:0] fifo_rdata;
  logic        data_ready, half_full, full, data_ready_n, half_full_n, full_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  a429_rx_filter u0 (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .lbl_chk_en(lbl_chk_en), .sdi_chk_en(sdi_chk_en), .sdi_match(sdi_match),
    .lbl_mode(lbl_mode), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .fifo_rd(fifo_rd),
    .fifo_rdata(fifo_rdata), .data_ready(data_ready), .half_full(half_full),
    .full(full), .data_ready_n(data_ready_n), .half_full_n(half_full_n),
    .full_n(full_n)
  );

  function automatic logic [7:0] lab(int i);
    return 8'h20 + 8'(i * 7);
  endfunction

  function automatic logic [31:0] mkw(logic [7:0] l, logic [1:0] s, logic [21:0] p);
    return {p, s, l};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    word_data = w; word_valid = 1'b1; tick(); word_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string req);
    fifo_rd = 1'b1; tick(); fifo_rd = 1'b0;
    chk(fifo_rdata == exp, req, fifo_rdata, exp);
  endtask

  task automatic host_write(input logic [7:0] v);
    host_wdata = v; host_wr = 1'b1; tick(); host_wr = 1'b0;
  endtask

  task automatic host_read();
    host_rd = 1'b1; tick(); host_rd = 1'b0;
  endtask

  task automatic mode_cycle(input logic m);
    lbl_mode = m; tick();
  endtask

  task automatic t_reset();
    chk(data_ready == 1'b0 && half_full == 1'b0 && full == 1'b0, "R1 flags", {data_ready, half_full, full}, 0);
    chk(data_ready_n && half_full_n && full_n, "R1 low pins", {data_ready_n, half_full_n, full_n}, 7);
    chk(fifo_rdata == 0, "R1 fifo_rdata", fifo_rdata, 0);
    chk(host_rdata == 0, "R1 host_rdata", host_rdata, 0);
    mode_cycle(1'b1);
    host_read();
    chk(host_rdata == 8'h00, "R1 table entry 0", host_rdata, 0);
    mode_cycle(1'b0);
  endtask

  task automatic t_labels();
    logic [7:0] held;
    mode_cycle(1'b1);
    for (int i = 0; i < 16; i++) host_write(lab(i));
    mode_cycle(1'b0);
    mode_cycle(1'b1);
    for (int i = 0; i < 16; i++) begin
      host_read();
      chk(host_rdata == lab(i), "R5 R6 readback order", host_rdata, lab(i));
    end
    host_read();
    chk(host_rdata == lab(0), "R6 wrap to entry 0", host_rdata, lab(0));
    mode_cycle(1'b0);
    held = host_rdata;
    host_write(8'hEE);
    host_read();
    chk(host_rdata == held, "R7 read ignored", host_rdata, held);
    mode_cycle(1'b1);
    host_read();
    chk(host_rdata == lab(0), "R7 write ignored", host_rdata, lab(0));
    host_write(8'h99);   // restart on the rise put the write pointer at 0
    mode_cycle(1'b0);
    mode_cycle(1'b1);
    host_read();
    chk(host_rdata == 8'h99, "R5 restart at entry 0", host_rdata, 8'h99);
    host_read();
    chk(host_rdata == lab(1), "R6 next entry", host_rdata, lab(1));
    mode_cycle(1'b0);
  endtask

  task automatic t_filter();
    // table now: 0x99, lab(1)..lab(15)
    lbl_chk_en = 1'b1; sdi_chk_en = 1'b0;
    send(mkw(lab(3), 2'b00, 22'h1));
    chk(data_ready == 1'b1, "R4 stored at strobe edge", data_ready, 1);
    send(mkw(8'h01, 2'b00, 22'h2));
    send(mkw(8'h99, 2'b11, 22'h3));
    pop_expect(mkw(lab(3), 2'b00, 22'h1), "R2 label hit");
    pop_expect(mkw(8'h99, 2'b11, 22'h3), "R2 unlisted label dropped");
    chk(data_ready == 1'b0, "R2 only hits stored", data_ready, 0);
    lbl_chk_en = 1'b0;
    send(mkw(8'h01, 2'b00, 22'h4));
    pop_expect(mkw(8'h01, 2'b00, 22'h4), "R2 check disabled");
    sdi_chk_en = 1'b1; sdi_match = 2'b10;
    send(mkw(8'h55, 2'b01, 22'h5));
    send(mkw(8'h55, 2'b11, 22'h6));
    send(mkw(8'h55, 2'b00, 22'h7));
    chk(data_ready == 1'b0, "R3 mismatches dropped", data_ready, 0);
    send(mkw(8'h55, 2'b10, 22'h8));
    pop_expect(mkw(8'h55, 2'b10, 22'h8), "R3 match stored");
    sdi_chk_en = 1'b0;
    send(mkw(8'h55, 2'b01, 22'h9));
    pop_expect(mkw(8'h55, 2'b01, 22'h9), "R3 check disabled");
    lbl_chk_en = 1'b1; sdi_chk_en = 1'b1; sdi_match = 2'b01;
    send(mkw(lab(7), 2'b10, 22'hA));
    send(mkw(8'h02, 2'b01, 22'hB));
    chk(data_ready == 1'b0, "R4 one failing check drops", data_ready, 0);
    send(mkw(lab(7), 2'b01, 22'hC));
    pop_expect(mkw(lab(7), 2'b01, 22'hC), "R4 both pass");
    chk(data_ready == 1'b0, "R9 empty after last read", data_ready, 0);
    lbl_chk_en = 1'b0; sdi_chk_en = 1'b0;
  endtask

  task automatic t_fill();
    logic [31:0] last;
    for (int i = 0; i < 32; i++) begin
      send(32'hA500_0000 + 32'(i));
      if (i == 0) chk(data_ready && !data_ready_n, "R9 R12 ready after one", {data_ready, data_ready_n}, 2'b10);
      if (i == 14) chk(half_full == 1'b0, "R10 15 words", half_full, 0);
      if (i == 15) chk(half_full && !half_full_n, "R10 R12 16 words", {half_full, half_full_n}, 2'b10);
      if (i == 30) chk(full == 1'b0, "R11 31 words", full, 0);
    end
    chk(full && !full_n, "R11 R12 32 words", {full, full_n}, 2'b10);
    send(32'hDEAD_0001);
    chk(full == 1'b1, "R11 still full after drop", full, 1);
    word_data = 32'hDEAD_0002; word_valid = 1'b1; fifo_rd = 1'b1;
    tick();
    word_valid = 1'b0; fifo_rd = 1'b0;
    chk(fifo_rdata == 32'hA500_0000, "R8 oldest first", fifo_rdata, 32'hA500_0000);
    chk(full == 1'b0, "R11 push with read while full dropped", full, 0);
    for (int i = 1; i < 32; i++) begin
      pop_expect(32'hA500_0000 + 32'(i), "R11 contents intact");
      if (i == 15) chk(half_full == 1'b1, "R10 16 left", half_full, 1);
      if (i == 16) chk(half_full == 1'b0 && half_full_n, "R10 15 left", half_full, 0);
    end
    chk(data_ready == 1'b0 && data_ready_n, "R9 R12 drained", data_ready, 0);
    last = fifo_rdata;
    fifo_rd = 1'b1; tick(); fifo_rd = 1'b0;
    chk(fifo_rdata == last, "R8 empty read holds data", fifo_rdata, last);
    chk(data_ready == 1'b0, "R8 empty read no change", data_ready, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst = 1'b1; word_valid = 1'b0; word_data = '0;
    lbl_chk_en = 1'b0; sdi_chk_en = 1'b0; sdi_match = 2'b00;
    lbl_mode = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0; fifo_rd = 1'b0;
    repeat (3) tick();
    t_reset_in_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_labels();
    t_filter();
    t_fill();
    done = 1'b1;
    finish_run();
  end

  task automatic t_reset_in_reset();
    chk(data_ready == 1'b0 && full_n == 1'b1, "R1 during reset", {data_ready, full_n}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end
endmodule